// File: doc/BRIEF.md
# Group-Allocated Load-Store Queue

This block orders memory traffic between a dynamically scheduled datapath and a single-port data memory. The datapath runs each loop iteration (one basic block) as a token. Before the block's operations run, a group token is sent to the queue. One accepted token reserves the whole access pattern of that block at once: one load slot and then one store slot. The load is older than the store. The order in which tokens are accepted is the program order for all memory accesses.

After allocation, the load port, the store-address port and the store-data port deliver their values whenever the datapath produces them. Each port delivers its own values in its own allocation order, but the three ports are not aligned with each other. The queue sends a load to memory as soon as every older uncommitted store has a known address that differs from the load's address. A load that matches an older store waits until that store has been written to memory. There is no store-to-load forwarding. Stores are written in allocation order. Load results come back on a result port in allocation order.

Loads go to memory in load-allocation order. One bank of comparators checks the oldest unissued load against every slot of the store queue. Both queue depths must be powers of two, and the store depth must be less than twice the load depth.

Top module: `grp_lsq`

## Requirements
- R1: Every accepted group token (grp_valid and grp_ready high at a clock edge) reserves one load slot followed by one store slot. grp_ready is low while the load queue holds LQ_DEPTH unretired loads or the store queue holds SQ_DEPTH uncommitted stores.
- R2: Every port moves a value only at an edge where both its valid and its ready are high. While mem_req_valid is high and mem_req_ready is low, the request (mem_req_we, mem_req_addr) stays unchanged. While ld_res_valid is high and ld_res_ready is low, ld_res_data stays unchanged.
- R3: Load addresses, store addresses and store data are accepted in any order relative to each other. Each port takes its values in its own allocation order, and its ready is high only while an allocated slot still lacks that value.
- R4: A load whose older uncommitted stores all have known addresses, none equal to its own, is read from memory without waiting for those stores' data or their commit.
- R5: A load whose address equals that of an older uncommitted store does not read memory until that store has been written. It then returns the stored value.
- R6: A load is held while any older uncommitted store has no address yet. It proceeds once that address arrives and does not match.
- R7: A store is written (mem_req_we = 1, with mem_req_addr and mem_req_wdata) only when its address and data are present and every older load has been read. Stores are written strictly in allocation order.
- R8: Load results appear on ld_res_data in load allocation order. Each result holds the memory word returned on mem_rsp_data for that load's read. Reads are answered in request order.
- R9: While rst_n is low, every queue is emptied. After reset, grp_ready is 1, and ld_res_valid, mem_req_valid, ld_addr_ready, st_addr_ready and st_data_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | Group token offered |
| grp_ready | output | 1 | Room for one load and one store |
| ld_addr_valid | input | 1 | Load address offered |
| ld_addr_ready | output | 1 | An allocated load still lacks its address |
| ld_addr | input | ADDR_W | Load address |
| st_addr_valid | input | 1 | Store address offered |
| st_addr_ready | output | 1 | An allocated store still lacks its address |
| st_addr | input | ADDR_W | Store address |
| st_data_valid | input | 1 | Store data offered |
| st_data_ready | output | 1 | An allocated store still lacks its data |
| st_data | input | DATA_W | Store data |
| ld_res_valid | output | 1 | Oldest load result available |
| ld_res_ready | input | 1 | Datapath takes the result |
| ld_res_data | output | DATA_W | Load result |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_ready | output | 1 | Always 1: every read already owns a result slot |
| mem_rsp_data | input | DATA_W | Read data |

## Verification
The hardest state to reach is a younger load that has its address and is blocked behind an older store, while that store's own load has already completed. Reaching it from the ports needs two groups whose port values arrive out of step. The directed tasks set this up by feeding both load addresses and both store addresses first and holding back store data, or by holding back one store address. The bench then counts results at that point, before releasing the missing value. A further task fills all eight groups before giving any address, so the full condition can be seen. A stalling memory-ready pattern keeps a request pending across several edges.

// File: rtl/grp_lsq_pkg.sv
package grp_lsq_pkg;
  // Which queue owns the single memory request port in a cycle.
  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_LOAD  = 2'd1,
    GNT_STORE = 2'd2
  } gnt_e;
endpackage

// File: rtl/grp_lsq_ldq.sv
// Load queue: circular buffer with allocate, address, issue, response and
// retire pointers. Each pointer carries one extra wrap bit.
module grp_lsq_ldq #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int TW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_i,
  input  logic [TW-1:0]            alloc_tag_i,
  input  logic                     addr_valid_i,
  output logic                     addr_ready_o,
  input  logic [AW-1:0]            addr_i,
  input  logic                     issue_i,
  input  logic                     rsp_valid_i,
  input  logic [DW-1:0]            rsp_data_i,
  output logic                     res_valid_o,
  input  logic                     res_ready_i,
  output logic [DW-1:0]            res_data_o,
  output logic                     space_o,
  output logic                     iss_avail_o,
  output logic [AW-1:0]            iss_addr_o,
  output logic [TW-1:0]            iss_tag_o,
  output logic [$clog2(DEPTH):0]   tail_o,
  output logic [$clog2(DEPTH):0]   iss_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic [PW-1:0] head_q, head_d, tail_q, tail_d, aptr_q, aptr_d;
  logic [PW-1:0] iss_q, iss_d, rsp_q, rsp_d;
  logic [AW-1:0] addr_q [DEPTH];
  logic [TW-1:0] tag_q  [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic          addr_we, res_fire;

  assign addr_ready_o = (aptr_q != tail_q);
  assign addr_we      = addr_valid_i & addr_ready_o;
  assign res_valid_o  = (head_q != rsp_q);
  assign res_fire     = res_valid_o & res_ready_i;
  assign res_data_o   = data_q[head_q[IW-1:0]];
  assign space_o      = ((tail_q - head_q) != PW'(DEPTH));
  assign iss_avail_o  = (iss_q != aptr_q);
  assign iss_addr_o   = addr_q[iss_q[IW-1:0]];
  assign iss_tag_o    = tag_q[iss_q[IW-1:0]];
  assign tail_o       = tail_q;
  assign iss_o        = iss_q;

  always_comb begin
    tail_d = tail_q + PW'(alloc_i);
    aptr_d = aptr_q + PW'(addr_we);
    iss_d  = iss_q  + PW'(issue_i);
    rsp_d  = rsp_q  + PW'(rsp_valid_i);
    head_d = head_q + PW'(res_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      aptr_q <= '0;
      iss_q  <= '0;
      rsp_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      aptr_q <= aptr_d;
      iss_q  <= iss_d;
      rsp_q  <= rsp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i)     tag_q[tail_q[IW-1:0]]  <= alloc_tag_i;
    if (addr_we)     addr_q[aptr_q[IW-1:0]] <= addr_i;
    if (rsp_valid_i) data_q[rsp_q[IW-1:0]]  <= rsp_data_i;
  end
endmodule

// File: rtl/grp_lsq_stq.sv
// Store queue: circular buffer with allocate, address, data and commit
// pointers. Every slot address is exported for the hazard scan.
module grp_lsq_stq #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int TW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_i,
  input  logic [TW-1:0]            alloc_tag_i,
  input  logic                     addr_valid_i,
  output logic                     addr_ready_o,
  input  logic [AW-1:0]            addr_i,
  input  logic                     data_valid_i,
  output logic                     data_ready_o,
  input  logic [DW-1:0]            data_i,
  input  logic                     commit_i,
  output logic                     space_o,
  output logic                     head_ok_o,
  output logic [AW-1:0]            head_addr_o,
  output logic [DW-1:0]            head_data_o,
  output logic [TW-1:0]            head_tag_o,
  output logic [$clog2(DEPTH):0]   head_o,
  output logic [$clog2(DEPTH):0]   tail_o,
  output logic [$clog2(DEPTH):0]   aptr_o,
  output logic [DEPTH*AW-1:0]      addr_flat_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [PW-1:0] aptr_q, aptr_d, dptr_q, dptr_d;
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [TW-1:0] tag_q  [DEPTH];
  logic          addr_we, data_we;

  assign addr_ready_o = (aptr_q != tail_q);
  assign data_ready_o = (dptr_q != tail_q);
  assign addr_we      = addr_valid_i & addr_ready_o;
  assign data_we      = data_valid_i & data_ready_o;
  assign space_o      = ((tail_q - head_q) != PW'(DEPTH));
  assign head_ok_o    = (head_q != aptr_q) && (head_q != dptr_q);
  assign head_addr_o  = addr_q[head_q[IW-1:0]];
  assign head_data_o  = data_q[head_q[IW-1:0]];
  assign head_tag_o   = tag_q[head_q[IW-1:0]];
  assign head_o       = head_q;
  assign tail_o       = tail_q;
  assign aptr_o       = aptr_q;

  for (genvar j = 0; j < DEPTH; j++) begin : g_flat
    assign addr_flat_o[j*AW +: AW] = addr_q[j];
  end

  always_comb begin
    tail_d = tail_q + PW'(alloc_i);
    aptr_d = aptr_q + PW'(addr_we);
    dptr_d = dptr_q + PW'(data_we);
    head_d = head_q + PW'(commit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      aptr_q <= '0;
      dptr_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      aptr_q <= aptr_d;
      dptr_q <= dptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i) tag_q[tail_q[IW-1:0]]  <= alloc_tag_i;
    if (addr_we) addr_q[aptr_q[IW-1:0]] <= addr_i;
    if (data_we) data_q[dptr_q[IW-1:0]] <= data_i;
  end
endmodule

// File: rtl/grp_lsq_hazard.sv
// Compares one load against every uncommitted store that is older than it.
// A store without an address counts as a conflict.
module grp_lsq_hazard #(
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic [$clog2(DEPTH):0] sq_head_i,
  input  logic [$clog2(DEPTH):0] sq_aptr_i,
  input  logic [$clog2(DEPTH):0] ld_tag_i,
  input  logic [AW-1:0]          ld_addr_i,
  input  logic [DEPTH*AW-1:0]    addr_flat_i,
  output logic                   blocked_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic [PW-1:0]    older_n, known_n;
  logic [DEPTH-1:0] hit;

  assign older_n = ld_tag_i  - sq_head_i;
  assign known_n = sq_aptr_i - sq_head_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_scan
    logic [IW-1:0] slot;
    assign slot   = sq_head_i[IW-1:0] + IW'(k);
    assign hit[k] = (PW'(k) < older_n) &&
                    ((PW'(k) >= known_n) ||
                     (addr_flat_i[slot*AW +: AW] == ld_addr_i));
  end

  assign blocked_o = |hit;
endmodule

// File: rtl/grp_lsq.sv
// Top level: group allocation, load/store selection for the memory port.
module grp_lsq
  import grp_lsq_pkg::*;
#(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_valid,
  output logic              grp_ready,
  input  logic              ld_addr_valid,
  output logic              ld_addr_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_addr_valid,
  output logic              st_addr_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_data_valid,
  output logic              st_data_ready,
  input  logic [DATA_W-1:0] st_data,
  output logic              ld_res_valid,
  input  logic              ld_res_ready,
  output logic [DATA_W-1:0] ld_res_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int LPW = $clog2(LQ_DEPTH) + 1;
  localparam int SPW = $clog2(SQ_DEPTH) + 1;

  logic              grp_fire, lq_space, sq_space;
  logic              ld_issue, st_commit, ld_avail, ld_blocked, ld_ok;
  logic              st_head_ok, st_ok;
  logic [LPW-1:0]    lq_tail, lq_iss, st_head_tag, ld_left, ld_after;
  logic [SPW-1:0]    sq_head, sq_tail, sq_aptr, ld_iss_tag;
  logic [ADDR_W-1:0] ld_iss_addr, st_head_addr;
  logic [DATA_W-1:0] st_head_data;
  logic [SQ_DEPTH*ADDR_W-1:0] sq_addr_flat;
  gnt_e              gnt, lock_q, lock_d;

  assign grp_ready     = lq_space & sq_space;
  assign grp_fire      = grp_valid & grp_ready;
  assign mem_rsp_ready = 1'b1;

  grp_lsq_ldq #(.DEPTH(LQ_DEPTH), .AW(ADDR_W), .DW(DATA_W), .TW(SPW)) u_ldq (
    .clk, .rst_n,
    .alloc_i(grp_fire), .alloc_tag_i(sq_tail),
    .addr_valid_i(ld_addr_valid), .addr_ready_o(ld_addr_ready), .addr_i(ld_addr),
    .issue_i(ld_issue),
    .rsp_valid_i(mem_rsp_valid), .rsp_data_i(mem_rsp_data),
    .res_valid_o(ld_res_valid), .res_ready_i(ld_res_ready), .res_data_o(ld_res_data),
    .space_o(lq_space), .iss_avail_o(ld_avail), .iss_addr_o(ld_iss_addr),
    .iss_tag_o(ld_iss_tag), .tail_o(lq_tail), .iss_o(lq_iss)
  );

  // The store of a group is younger than the load of the same group.
  grp_lsq_stq #(.DEPTH(SQ_DEPTH), .AW(ADDR_W), .DW(DATA_W), .TW(LPW)) u_stq (
    .clk, .rst_n,
    .alloc_i(grp_fire), .alloc_tag_i(lq_tail + LPW'(1)),
    .addr_valid_i(st_addr_valid), .addr_ready_o(st_addr_ready), .addr_i(st_addr),
    .data_valid_i(st_data_valid), .data_ready_o(st_data_ready), .data_i(st_data),
    .commit_i(st_commit), .space_o(sq_space), .head_ok_o(st_head_ok),
    .head_addr_o(st_head_addr), .head_data_o(st_head_data), .head_tag_o(st_head_tag),
    .head_o(sq_head), .tail_o(sq_tail), .aptr_o(sq_aptr), .addr_flat_o(sq_addr_flat)
  );

  grp_lsq_hazard #(.DEPTH(SQ_DEPTH), .AW(ADDR_W)) u_haz (
    .sq_head_i(sq_head), .sq_aptr_i(sq_aptr), .ld_tag_i(ld_iss_tag),
    .ld_addr_i(ld_iss_addr), .addr_flat_i(sq_addr_flat), .blocked_o(ld_blocked)
  );

  assign ld_ok = ld_avail & ~ld_blocked;

  // Older loads all issued: the unissued loads all lie after this store.
  assign ld_left  = lq_tail - lq_iss;
  assign ld_after = lq_tail - st_head_tag;
  assign st_ok    = st_head_ok & (ld_left <= ld_after);

  // Stores first; a request waiting on mem_req_ready keeps the port.
  always_comb begin
    if (lock_q != GNT_NONE) gnt = lock_q;
    else if (st_ok)         gnt = GNT_STORE;
    else if (ld_ok)         gnt = GNT_LOAD;
    else                    gnt = GNT_NONE;
    lock_d = (mem_req_valid && !mem_req_ready) ? gnt : GNT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= GNT_NONE;
    else        lock_q <= lock_d;
  end

  assign mem_req_valid = (gnt != GNT_NONE);
  assign mem_req_we    = (gnt == GNT_STORE);
  assign mem_req_addr  = mem_req_we ? st_head_addr : ld_iss_addr;
  assign mem_req_wdata = st_head_data;
  assign ld_issue      = mem_req_ready & (gnt == GNT_LOAD);
  assign st_commit     = mem_req_ready & (gnt == GNT_STORE);
endmodule

// File: rtl/grp_lsq_chk.sv
module grp_lsq_chk #(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grp_valid,
  input logic              grp_ready,
  input logic              st_addr_ready,
  input logic              ld_res_valid,
  input logic              ld_res_ready,
  input logic [DATA_W-1:0] ld_res_data,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr
);
  logic [$clog2(LQ_DEPTH)+1:0] lq_occ;
  logic [$clog2(SQ_DEPTH)+1:0] sq_occ;
  logic grp_fire, res_fire, wr_fire;

  assign grp_fire = grp_valid & grp_ready;
  assign res_fire = ld_res_valid & ld_res_ready;
  assign wr_fire  = mem_req_valid & mem_req_ready & mem_req_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lq_occ <= '0;
      sq_occ <= '0;
    end else begin
      lq_occ <= lq_occ + ($bits(lq_occ))'(grp_fire) - ($bits(lq_occ))'(res_fire);
      sq_occ <= sq_occ + ($bits(sq_occ))'(grp_fire) - ($bits(sq_occ))'(wr_fire);
    end
  end

  AST_LQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    lq_occ <= ($bits(lq_occ))'(LQ_DEPTH)); // R1
  AST_SQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sq_occ <= ($bits(sq_occ))'(SQ_DEPTH)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)); // R2
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_res_valid && !ld_res_ready |=> ld_res_valid && $stable(ld_res_data)); // R2
  AST_ST_ADDR_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    st_addr_ready |-> sq_occ != '0); // R3
  AST_RES_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_res_valid |-> lq_occ != '0); // R8
endmodule

bind grp_lsq grp_lsq_chk #(
  .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
  .st_addr_ready(st_addr_ready), .ld_res_valid(ld_res_valid),
  .ld_res_ready(ld_res_ready), .ld_res_data(ld_res_data),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr)
);

// File: tb/grp_lsq_tb.sv
module grp_lsq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grp_valid = 1'b0, grp_ready;
  logic        ld_addr_valid = 1'b0, ld_addr_ready;
  logic [7:0]  ld_addr = '0;
  logic        st_addr_valid = 1'b0, st_addr_ready;
  logic [7:0]  st_addr = '0;
  logic        st_data_valid = 1'b0, st_data_ready;
  logic [15:0] st_data = '0;
  logic        ld_res_valid, ld_res_ready = 1'b1;
  logic [15:0] ld_res_data;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [7:0]  mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [15:0] mem_rsp_data = '0;

  logic [15:0] mem [256];
  logic [7:0]  wr_log [64];
  logic [15:0] res_log [64];
  int          wr_n, res_n;
  logic [1:0]  cyc3;
  logic        mem_stall = 1'b0;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  grp_lsq u_dut (
    .clk, .rst_n, .grp_valid, .grp_ready,
    .ld_addr_valid, .ld_addr_ready, .ld_addr,
    .st_addr_valid, .st_addr_ready, .st_addr,
    .st_data_valid, .st_data_ready, .st_data,
    .ld_res_valid, .ld_res_ready, .ld_res_data,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data
  );

  assign mem_req_ready = !mem_stall || (cyc3 == 2'd0);

  // Memory model (one-cycle read latency) and result/write monitors.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'h1000 + 16'(i);
      wr_n <= 0;
      res_n <= 0;
      cyc3 <= 2'd0;
      mem_rsp_valid <= 1'b0;
    end else begin
      cyc3 <= (cyc3 == 2'd2) ? 2'd0 : cyc3 + 2'd1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr] <= mem_req_wdata;
          wr_log[wr_n] <= mem_req_addr;
          wr_n <= wr_n + 1;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr];
        end
      end
      if (ld_res_valid && ld_res_ready) begin
        res_log[res_n] <= ld_res_data;
        res_n <= res_n + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_grp();
    @(negedge clk); grp_valid = 1'b1;
    while (!grp_ready) @(negedge clk);
    @(negedge clk); grp_valid = 1'b0;
  endtask

  task automatic send_ld(input logic [7:0] a);
    @(negedge clk); ld_addr_valid = 1'b1; ld_addr = a;
    while (!ld_addr_ready) @(negedge clk);
    @(negedge clk); ld_addr_valid = 1'b0;
  endtask

  task automatic send_sa(input logic [7:0] a);
    @(negedge clk); st_addr_valid = 1'b1; st_addr = a;
    while (!st_addr_ready) @(negedge clk);
    @(negedge clk); st_addr_valid = 1'b0;
  endtask

  task automatic send_sd(input logic [15:0] d);
    @(negedge clk); st_data_valid = 1'b1; st_data = d;
    while (!st_data_ready) @(negedge clk);
    @(negedge clk); st_data_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9", "grp_ready", 32'(grp_ready), 1);
    check("R9", "ld_res_valid", 32'(ld_res_valid), 0);
    check("R9", "mem_req_valid", 32'(mem_req_valid), 0);
    check("R9", "ld_addr_ready", 32'(ld_addr_ready), 0);
    check("R9", "st_addr_ready", 32'(st_addr_ready), 0);
    check("R9", "st_data_ready", 32'(st_data_ready), 0);
  endtask

  // R4: loads bypass stores that have distinct known addresses but no data.
  task automatic t_distinct();
    int r0, w0;
    r0 = res_n; w0 = wr_n;
    mem_stall = 1'b1;
    send_grp(); send_grp();
    send_sa(8'd20); send_sa(8'd21);
    send_ld(8'd10); send_ld(8'd11);
    idle(20);
    check("R4", "results before store data", 32'(res_n - r0), 2);
    check("R8", "first result", 32'(res_log[r0]), 32'h100A);
    check("R8", "second result", 32'(res_log[r0+1]), 32'h100B);
    check("R7", "no write without data", 32'(wr_n - w0), 0);
    send_sd(16'hAAAA); send_sd(16'hBBBB);
    idle(20);
    check("R7", "mem[20]", 32'(mem[20]), 32'hAAAA);
    check("R7", "mem[21]", 32'(mem[21]), 32'hBBBB);
    mem_stall = 1'b0;
  endtask

  // R5: two iterations on address 4.
  task automatic t_raw();
    int r0;
    r0 = res_n;
    send_grp(); send_grp();
    send_ld(8'd4); send_ld(8'd4);
    send_sa(8'd4); send_sa(8'd4);
    idle(10);
    check("R5", "younger load held", 32'(res_n - r0), 1);
    check("R5", "older load value", 32'(res_log[r0]), 32'h1004);
    send_sd(16'h1234);
    idle(10);
    check("R5", "younger load sees store", 32'(res_log[r0+1]), 32'h1234);
    send_sd(16'h5678);
    idle(10);
    check("R5", "final mem[4]", 32'(mem[4]), 32'h5678);
  endtask

  // R6: unknown older store address blocks a younger load.
  task automatic t_unknown();
    int r0;
    r0 = res_n;
    send_grp(); send_grp();
    send_ld(8'd30); send_ld(8'd31);
    idle(10);
    check("R6", "held on unknown address", 32'(res_n - r0), 1);
    send_sa(8'd33);
    idle(10);
    check("R6", "released after address", 32'(res_n - r0), 2);
    check("R6", "released value", 32'(res_log[r0+1]), 32'h101F);
    send_sd(16'h3333); send_sa(8'd32); send_sd(16'h3232);
    idle(10);
    check("R6", "mem[33]", 32'(mem[33]), 32'h3333);
  endtask

  // R3/R7: data and addresses before load addresses; writes in order.
  task automatic t_order();
    int r0, w0;
    r0 = res_n; w0 = wr_n;
    for (int i = 0; i < 3; i++) send_grp();
    for (int i = 0; i < 3; i++) send_sd(16'h00D0 + 16'(i));
    for (int i = 0; i < 3; i++) send_sa(8'd50 + 8'(i));
    idle(10);
    check("R7", "stores wait for older loads", 32'(wr_n - w0), 0);
    for (int i = 0; i < 3; i++) send_ld(8'd40 + 8'(i));
    idle(20);
    check("R3", "results after late load addresses", 32'(res_n - r0), 3);
    for (int i = 0; i < 3; i++)
      check("R7", "write order", 32'(wr_log[w0+i]), 32'(50 + i));
    check("R8", "third result", 32'(res_log[r0+2]), 32'h102A);
    check("R7", "mem[52]", 32'(mem[52]), 32'h00D2);
  endtask

  // R1: eight groups fill both queues.
  task automatic t_full();
    int r0;
    r0 = res_n;
    for (int i = 0; i < 8; i++) send_grp();
    @(negedge clk);
    check("R1", "grp_ready when full", 32'(grp_ready), 0);
    for (int i = 0; i < 8; i++) send_ld(8'd60 + 8'(i));
    for (int i = 0; i < 8; i++) send_sa(8'd70 + 8'(i));
    for (int i = 0; i < 8; i++) send_sd(16'h7000 + 16'(i));
    idle(40);
    check("R1", "grp_ready after drain", 32'(grp_ready), 1);
    check("R1", "result count", 32'(res_n - r0), 8);
    check("R8", "last result", 32'(res_log[r0+7]), 32'h1043);
    check("R7", "mem[77]", 32'(mem[77]), 32'h7007);
  endtask

  // R2: result held while the consumer stalls.
  task automatic t_stall();
    int r0;
    logic [15:0] held;
    r0 = res_n;
    ld_res_ready = 1'b0;
    send_grp(); send_ld(8'd80); send_sa(8'd81); send_sd(16'h8181);
    idle(8);
    check("R2", "result valid while stalled", 32'(ld_res_valid), 1);
    held = ld_res_data;
    check("R2", "stalled data", 32'(held), 32'h1050);
    idle(3);
    check("R2", "data stable", 32'(ld_res_data), 32'(held));
    check("R2", "nothing taken", 32'(res_n - r0), 0);
    ld_res_ready = 1'b1;
    idle(3);
    check("R2", "taken after release", 32'(res_log[r0]), 32'h1050);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_distinct();
    t_raw();
    t_unknown();
    t_order();
    t_full();
    t_stall();
    idle(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule